// File: doc/BRIEF.md
# Page-Mode Write Load Buffer

This block sits between a parallel host bus and the programming engine of a byte-addressed nonvolatile memory. The host writes bytes using the chip-enable, write-enable and output-enable strobes. The block collects them into a buffer the size of one page. Each strobe selects a byte slot through the low address bits. The upper address bits choose the page, and they must stay the same for the whole load period.

The load period starts with the first accepted byte and closes on its own. It closes when no further byte arrives within a fixed inactivity window. At that point the block raises a one-cycle commit. The commit carries the page address, the buffered bytes and a per-slot valid mask, so the engine programs only the slots that were written.

While the engine reports busy, the block drops host strobes. It also discards strobes that are too short to be genuine. A byte aimed at a different page is discarded as well, and sets a sticky error flag.

Top module: `page_load_buf`

## Requirements
- R1: One load period takes between 1 and 64 bytes, and all of them leave in a single one-cycle `commit_o` pulse, with a non-zero `commit_mask_o`.
- R2: Address bits [14:6] of the first accepted byte become the page. `commit_page_o` stays steady for the rest of the load period and is the page reported at commit.
- R3: Address bits [5:0] select the slot: bit n of `commit_mask_o` corresponds to data bits [8n+7:8n] of `commit_data_o`. Slots may be written in any order, and a rewritten slot keeps its latest byte.
- R4: `commit_o` rises exactly `WIN_CYC` clock cycles after the clock edge that accepted the last byte, and `loading_o` falls one cycle later.
- R5: `commit_mask_o` has bits set only for slots loaded in the current period. It is cleared in the cycle after the commit.
- R6: A strobe is active while `ce_ni`=0, `we_ni`=0 and `oe_ni`=1. The address is taken when the later of the two enables falls. The byte is the data present on the last cycle before the earlier enable rises.
- R7: A strobe that is active for fewer than `MIN_PULSE` clock cycles is ignored. A strobe active for exactly `MIN_PULSE` cycles is accepted.
- R8: While `busy_i` is 1, strobes are ignored and no load period starts.
- R9: A strobe whose page bits differ from the current page is dropped without changing the mask. It sets `page_err_o`, which stays set until reset.
- R10: `loading_o` is 1 from the first accepted byte until the commit cycle, inclusive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ce_ni | input | 1 | Chip enable, active low |
| we_ni | input | 1 | Write enable, active low |
| oe_ni | input | 1 | Output enable, active low; must be high to write |
| addr_i | input | 15 | Byte address: page in [14:6], slot in [5:0] |
| data_i | input | 8 | Write data |
| busy_i | input | 1 | Programming engine busy |
| commit_o | output | 1 | One-cycle hand-off of the loaded page |
| commit_page_o | output | 9 | Page being loaded or committed |
| commit_data_o | output | 512 | Buffered bytes, slot n in bits [8n+7:8n] |
| commit_mask_o | output | 64 | Per-slot loaded flags |
| loading_o | output | 1 | Load period open |
| page_err_o | output | 1 | Sticky page-mismatch flag |

## Verification
The bench builds the block with `WIN_CYC`=20 and `MIN_PULSE`=3. The short window lets the timeout be counted to the exact cycle and lets a full 64-slot page be loaded quickly. The small pulse minimum puts the accept/reject boundary between 2-cycle and 3-cycle strobes. A busy countdown of 8 cycles follows each commit, so writes issued while the engine is busy fall into a short, reachable interval.

// File: rtl/page_load_pkg.sv
package page_load_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_LOAD = 1'b1
  } load_state_e;
endpackage

// File: rtl/pl_strobe_filter.sv
module pl_strobe_filter #(
  parameter int ADDR_W    = 15,
  parameter int DATA_W    = 8,
  parameter int MIN_PULSE = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ce_ni,
  input  logic              we_ni,
  input  logic              oe_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              wr_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [DATA_W-1:0] wr_data_o
);
  localparam int CNT_W = $clog2(MIN_PULSE + 1);

  logic              act, act_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;

  assign act = ~ce_ni & ~we_ni & oe_ni;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q  <= 1'b0;
      cnt_q  <= '0;
      addr_q <= '0;
      data_q <= '0;
    end else begin
      act_q <= act;
      // address on the later falling enable = start of the active window
      if (act && !act_q) begin
        addr_q <= addr_i;
        cnt_q  <= CNT_W'(1);
      end else if (act && cnt_q != CNT_W'(MIN_PULSE)) begin
        cnt_q <= cnt_q + CNT_W'(1);
      end
      if (act) data_q <= data_i;
    end
  end

  assign wr_o      = act_q & ~act & (cnt_q >= CNT_W'(MIN_PULSE));
  assign wr_addr_o = addr_q;
  assign wr_data_o = data_q;
endmodule

// File: rtl/pl_page_store.sv
module pl_page_store #(
  parameter int SLOT_W = 6,
  parameter int DATA_W = 8
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      wr_i,
  input  logic [SLOT_W-1:0]         slot_i,
  input  logic [DATA_W-1:0]         data_i,
  input  logic                      clr_i,
  output logic [(1<<SLOT_W)*DATA_W-1:0] data_o,
  output logic [(1<<SLOT_W)-1:0]    mask_o
);
  localparam int SLOTS = 1 << SLOT_W;

  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    logic [DATA_W-1:0] byte_q;
    logic              vld_q;
    logic              hit;

    assign hit = wr_i && (slot_i == SLOT_W'(g));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        byte_q <= '0;
        vld_q  <= 1'b0;
      end else begin
        if (hit) byte_q <= data_i;
        if (clr_i)    vld_q <= 1'b0;
        else if (hit) vld_q <= 1'b1;
      end
    end

    assign data_o[g*DATA_W +: DATA_W] = byte_q;
    assign mask_o[g]                  = vld_q;
  end
endmodule

// File: rtl/pl_load_ctrl.sv
module pl_load_ctrl
  import page_load_pkg::*;
#(
  parameter int PAGE_W  = 9,
  parameter int WIN_CYC = 1000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [PAGE_W-1:0] wr_page_i,
  input  logic              busy_i,
  output logic              accept_o,
  output logic              commit_o,
  output logic              loading_o,
  output logic [PAGE_W-1:0] page_o,
  output logic              err_o
);
  localparam int TMR_W = $clog2(WIN_CYC);

  load_state_e       state_q;
  logic [TMR_W-1:0]  tmr_q;
  logic [PAGE_W-1:0] page_q;
  logic              err_q;
  logic              live_wr, same_pg, mismatch, expire;

  assign live_wr  = wr_i & ~busy_i;
  assign same_pg  = (wr_page_i == page_q);
  assign accept_o = live_wr & ((state_q == ST_IDLE) | same_pg);
  assign mismatch = live_wr & (state_q == ST_LOAD) & ~same_pg;
  assign expire   = (state_q == ST_LOAD) && (tmr_q == TMR_W'(WIN_CYC - 1)) && !accept_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      tmr_q   <= '0;
      page_q  <= '0;
      err_q   <= 1'b0;
    end else begin
      if (mismatch) err_q <= 1'b1;
      unique case (state_q)
        ST_IDLE: if (accept_o) begin
          state_q <= ST_LOAD;
          page_q  <= wr_page_i;
          tmr_q   <= '0;
        end
        ST_LOAD: begin
          if (accept_o)    tmr_q   <= '0;
          else if (expire) state_q <= ST_IDLE;
          else             tmr_q   <= tmr_q + TMR_W'(1);
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign commit_o  = expire;
  assign loading_o = (state_q == ST_LOAD);
  assign page_o    = page_q;
  assign err_o     = err_q;
endmodule

// File: rtl/page_load_buf.sv
module page_load_buf #(
  parameter int ADDR_W    = 15,
  parameter int SLOT_W    = 6,
  parameter int DATA_W    = 8,
  parameter int WIN_CYC   = 1000,
  parameter int MIN_PULSE = 2
) (
  input  logic                                clk_i,
  input  logic                                rst_ni,
  input  logic                                ce_ni,
  input  logic                                we_ni,
  input  logic                                oe_ni,
  input  logic [ADDR_W-1:0]                   addr_i,
  input  logic [DATA_W-1:0]                   data_i,
  input  logic                                busy_i,
  output logic                                commit_o,
  output logic [ADDR_W-SLOT_W-1:0]            commit_page_o,
  output logic [(1<<SLOT_W)*DATA_W-1:0]       commit_data_o,
  output logic [(1<<SLOT_W)-1:0]              commit_mask_o,
  output logic                                loading_o,
  output logic                                page_err_o
);
  localparam int PAGE_W = ADDR_W - SLOT_W;
  localparam int SLOTS  = 1 << SLOT_W;

  logic              wr;
  logic [ADDR_W-1:0] wr_addr;
  logic [DATA_W-1:0] wr_data;
  logic              accept;
  logic              commit;

  pl_strobe_filter #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .MIN_PULSE(MIN_PULSE)
  ) u_filt (
    .clk_i, .rst_ni, .ce_ni, .we_ni, .oe_ni, .addr_i, .data_i,
    .wr_o(wr), .wr_addr_o(wr_addr), .wr_data_o(wr_data)
  );

  pl_load_ctrl #(
    .PAGE_W(PAGE_W), .WIN_CYC(WIN_CYC)
  ) u_ctrl (
    .clk_i, .rst_ni,
    .wr_i(wr), .wr_page_i(wr_addr[ADDR_W-1:SLOT_W]), .busy_i,
    .accept_o(accept), .commit_o(commit), .loading_o,
    .page_o(commit_page_o), .err_o(page_err_o)
  );

  pl_page_store #(
    .SLOT_W(SLOT_W), .DATA_W(DATA_W)
  ) u_store (
    .clk_i, .rst_ni,
    .wr_i(accept), .slot_i(wr_addr[SLOT_W-1:0]), .data_i(wr_data),
    .clr_i(commit), .data_o(commit_data_o), .mask_o(commit_mask_o)
  );

  assign commit_o = commit;
endmodule

// File: rtl/page_load_buf_chk.sv
module page_load_buf_chk #(
  parameter int PAGE_W = 9,
  parameter int SLOTS  = 64
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              busy_i,
  input logic              commit_o,
  input logic [PAGE_W-1:0] commit_page_o,
  input logic [SLOTS-1:0]  commit_mask_o,
  input logic              loading_o,
  input logic              page_err_o
);
  assert_commit_nonempty_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_o |-> commit_mask_o != '0);

  assert_page_steady_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (loading_o && !commit_o) |=> $stable(commit_page_o));

  assert_commit_single_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_o |=> (!commit_o && !loading_o));

  assert_mask_cleared_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_o |=> commit_mask_o == '0);

  assert_busy_blocks_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && !loading_o) |=> !loading_o);

  assert_err_sticky_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    page_err_o |=> page_err_o);

  assert_commit_in_load_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_o |-> loading_o);

  assert_idle_mask_empty_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !loading_o |-> commit_mask_o == '0);
endmodule

bind page_load_buf page_load_buf_chk #(.PAGE_W(PAGE_W), .SLOTS(SLOTS)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .busy_i(busy_i), .commit_o(commit_o),
  .commit_page_o(commit_page_o), .commit_mask_o(commit_mask_o),
  .loading_o(loading_o), .page_err_o(page_err_o)
);

// File: tb/sim_page_load_buf.sv
`timescale 1ns/1ps
module sim_page_load_buf;
  localparam int WIN  = 20;
  localparam int MINP = 3;
  localparam int PROG = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
  logic [14:0]  addr = '0;
  logic [7:0]   data = '0;
  logic         busy;
  logic         force_busy = 1'b0;
  logic         commit;
  logic [8:0]   c_page;
  logic [511:0] c_data;
  logic [63:0]  c_mask;
  logic         loading, perr;

  int n_chk = 0, n_fail = 0, n_commit = 0;
  logic [8:0]   cap_page;
  logic [511:0] cap_data;
  logic [63:0]  cap_mask;
  int busy_cnt = 0;

  always #5 clk = ~clk;

  page_load_buf #(.WIN_CYC(WIN), .MIN_PULSE(MINP)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .ce_ni(ce_n), .we_ni(we_n), .oe_ni(oe_n),
    .addr_i(addr), .data_i(data), .busy_i(busy), .commit_o(commit),
    .commit_page_o(c_page), .commit_data_o(c_data), .commit_mask_o(c_mask),
    .loading_o(loading), .page_err_o(perr)
  );

  // programming engine model: busy countdown after each commit
  always @(posedge clk) begin
    if (commit) busy_cnt <= PROG;
    else if (busy_cnt != 0) busy_cnt <= busy_cnt - 1;
  end
  assign busy = (busy_cnt != 0) || force_busy;

  always @(negedge clk) begin
    if (commit) begin
      n_commit <= n_commit + 1;
      cap_page <= c_page;
      cap_data <= c_data;
      cap_mask <= c_mask;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr_byte(input logic [14:0] a, input logic [7:0] d, input int hold = 4);
    @(negedge clk);
    addr = a; data = d; oe_n = 1'b1; ce_n = 1'b0; we_n = 1'b0;
    repeat (hold) @(negedge clk);
    we_n = 1'b1; ce_n = 1'b1;
  endtask

  task automatic gap(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic settle();
    repeat (WIN + PROG + 6) @(negedge clk);
  endtask

  task automatic t_reset();
    chk(commit == 1'b0, "R1 reset commit", 64'(commit), 0);
    chk(loading == 1'b0, "R10 reset loading", 64'(loading), 0);
    chk(perr == 1'b0, "R9 reset err", 64'(perr), 0);
    chk(c_mask == '0, "R5 reset mask", c_mask, 0);
  endtask

  task automatic t_single();
    int n0 = n_commit;
    wr_byte({9'h0A5, 6'd7}, 8'h3C);
    gap(2);
    chk(loading == 1'b1, "R10 loading after byte", 64'(loading), 1);
    settle();
    chk(n_commit == n0 + 1, "R1 single commit", 64'(n_commit - n0), 1);
    chk(cap_page == 9'h0A5, "R2 page", 64'(cap_page), 64'h0A5);
    chk(cap_mask == 64'h80, "R5 single mask", cap_mask, 64'h80);
    chk(cap_data[7*8 +: 8] == 8'h3C, "R3 slot7 data", 64'(cap_data[7*8 +: 8]), 64'h3C);
  endtask

  task automatic t_multi();
    int n0 = n_commit;
    wr_byte({9'h012, 6'd40}, 8'h11); gap(2);
    wr_byte({9'h012, 6'd3},  8'h22); gap(2);
    wr_byte({9'h012, 6'd63}, 8'h33); gap(2);
    wr_byte({9'h012, 6'd3},  8'h44);
    settle();
    chk(n_commit == n0 + 1, "R1 multi one commit", 64'(n_commit - n0), 1);
    chk(cap_mask == ((64'd1 << 3) | (64'd1 << 40) | (64'd1 << 63)), "R5 multi mask",
        cap_mask, (64'd1 << 3) | (64'd1 << 40) | (64'd1 << 63));
    chk(cap_data[3*8 +: 8] == 8'h44, "R3 rewrite slot3", 64'(cap_data[3*8 +: 8]), 64'h44);
    chk(cap_data[40*8 +: 8] == 8'h11, "R3 slot40", 64'(cap_data[40*8 +: 8]), 64'h11);
    chk(cap_data[63*8 +: 8] == 8'h33, "R3 slot63", 64'(cap_data[63*8 +: 8]), 64'h33);
  endtask

  task automatic t_full();
    int n0 = n_commit;
    int bad = 0;
    for (int i = 63; i >= 0; i--) begin
      wr_byte({9'h1FF, 6'(i)}, 8'(i) ^ 8'h5A, 3);
      gap(1);
    end
    settle();
    chk(n_commit == n0 + 1, "R1 full page one commit", 64'(n_commit - n0), 1);
    chk(cap_mask == '1, "R1 full mask", cap_mask, '1);
    for (int i = 0; i < 64; i++)
      if (cap_data[i*8 +: 8] != (8'(i) ^ 8'h5A)) bad++;
    chk(bad == 0, "R3 full data", 64'(bad), 0);
  endtask

  task automatic t_timeout();
    int k = 0;
    wr_byte({9'h044, 6'd0}, 8'h01);
    while (!commit && k < 4 * WIN) begin
      @(negedge clk);
      k++;
    end
    chk(k == WIN, "R4 timeout cycles", 64'(k), 64'(WIN));
    @(negedge clk);
    chk(loading == 1'b0, "R4 loading drops", 64'(loading), 0);
    settle();
  endtask

  task automatic t_glitch();
    int n0 = n_commit;
    wr_byte({9'h055, 6'd2}, 8'hEE, MINP - 1);
    gap(3);
    chk(loading == 1'b0, "R7 short pulse ignored", 64'(loading), 0);
    settle();
    chk(n_commit == n0, "R7 no commit", 64'(n_commit - n0), 0);
    wr_byte({9'h055, 6'd2}, 8'hED, MINP);
    gap(2);
    chk(loading == 1'b1, "R7 min pulse accepted", 64'(loading), 1);
    settle();
    chk(cap_data[2*8 +: 8] == 8'hED, "R7 min pulse data", 64'(cap_data[2*8 +: 8]), 64'hED);
  endtask

  task automatic t_busy();
    int n0 = n_commit;
    force_busy = 1'b1;
    wr_byte({9'h066, 6'd9}, 8'h99);
    gap(3);
    chk(loading == 1'b0, "R8 busy ignores", 64'(loading), 0);
    force_busy = 1'b0;
    settle();
    chk(n_commit == n0, "R8 no commit", 64'(n_commit - n0), 0);
    chk(c_mask == '0, "R8 mask untouched", c_mask, 0);
  endtask

  task automatic t_capture();
    @(negedge clk); addr = {9'h030, 6'd5}; data = 8'h00; we_n = 1'b0; ce_n = 1'b1;
    @(negedge clk); addr = {9'h031, 6'd9}; data = 8'h01; ce_n = 1'b0;
    @(negedge clk); addr = {9'h032, 6'd12}; data = 8'h02;
    @(negedge clk); data = 8'h77;
    @(negedge clk); ce_n = 1'b1; data = 8'hFF;
    @(negedge clk); we_n = 1'b1;
    settle();
    chk(cap_page == 9'h031, "R6 addr at later fall", 64'(cap_page), 64'h031);
    chk(cap_mask == (64'd1 << 9), "R6 slot", cap_mask, 64'd1 << 9);
    chk(cap_data[9*8 +: 8] == 8'h77, "R6 data before earlier rise", 64'(cap_data[9*8 +: 8]), 64'h77);
  endtask

  task automatic t_mismatch();
    wr_byte({9'h020, 6'd1}, 8'hAA); gap(2);
    wr_byte({9'h021, 6'd2}, 8'hBB); gap(2);
    chk(perr == 1'b1, "R9 err set", 64'(perr), 1);
    settle();
    chk(cap_mask == 64'h2, "R9 mismatch dropped", cap_mask, 64'h2);
    chk(cap_page == 9'h020, "R9 page kept", 64'(cap_page), 64'h020);
    chk(perr == 1'b1, "R9 err sticky", 64'(perr), 1);
  endtask

  initial begin
    #(200000 * 10);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    gap(2);
    t_single();
    t_multi();
    t_full();
    t_timeout();
    t_glitch();
    t_busy();
    t_capture();
    t_mismatch();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule